// File: doc/BRIEF.md
# Sector Protection Lock Controller

This block owns a single volatile lock flag that decides whether the per-sector protection bits of a flash command interface may be rewritten. A non-volatile mode input chooses one of two protection schemes. In password mode the flag comes out of every reset set and can only be dropped by an unlock command that carries a matching password. In persistent mode the flag comes out of every reset clear, a lock-set command raises it, and from then on only another reset lowers it.

Command decoding, password storage and the comparison itself live elsewhere. This block receives already decoded single-cycle strobes for lock-set and password-unlock, plus the result of the password comparison. It returns the flag, an enable that permits modification of the protection bits, and a one-cycle flag that reports a rejected unlock attempt. All state changes appear after the rising clock edge that samples the stimulus. Both reset inputs are synchronous and active-high.

Top module: `sprot_lock_ctrl`

## Requirements
- R1: With `mode_nv` = 1 (password mode) during a cycle where `por` or `hw_rst` is high, `lock_o` reads 1 after that edge.
- R2: With `mode_nv` = 0 (persistent mode) during a cycle where `por` or `hw_rst` is high, `lock_o` reads 0 after that edge.
- R3: Outside reset, a `cmd_lock_set` strobe makes `lock_o` 1 after the edge, in either mode.
- R4: In password mode, a `cmd_pw_unlock` strobe with `pw_match` = 1 (and no lock-set) makes `lock_o` 0 after the edge, and `unlock_fail_o` stays 0.
- R5: In password mode, a `cmd_pw_unlock` strobe with `pw_match` = 0 leaves `lock_o` unchanged and raises `unlock_fail_o` for exactly the one following cycle.
- R6: In persistent mode, `cmd_pw_unlock` is ignored: `lock_o` keeps its value and `unlock_fail_o` stays 0, whatever `pw_match` is.
- R7: In persistent mode, once `lock_o` is 1 it stays 1 until a reset; no command lowers it.
- R8: `prot_mod_en_o` is 1 exactly when `lock_o` is 0 and neither reset input is high.
- R9: The mode is captured from `mode_nv` on each reset cycle and held; changes of `mode_nv` outside reset have no effect on command handling.
- R10: When `cmd_lock_set` and `cmd_pw_unlock` arrive in the same cycle, the lock-set wins: `lock_o` becomes 1 and `unlock_fail_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active-high |
| hw_rst | input | 1 | Hardware reset, synchronous, active-high |
| mode_nv | input | 1 | Non-volatile mode: 1 = password, 0 = persistent |
| cmd_lock_set | input | 1 | Decoded lock-set command strobe |
| cmd_pw_unlock | input | 1 | Decoded password-unlock command strobe |
| pw_match | input | 1 | Password comparison result for the unlock strobe |
| lock_o | output | 1 | Current lock flag |
| prot_mod_en_o | output | 1 | Protection bits may be modified |
| unlock_fail_o | output | 1 | One-cycle pulse after a rejected unlock |

## Verification
The command logic is driven with seeded random mixes of both reset sources, both modes, both strobes and match results, against a bench reference model; this separates the mode-dependent reset value, the lock-set priority and the match/mismatch paths cycle by cycle. Directed sequences then target the cases random traffic rarely lines up: a matching unlock in persistent mode after lock-set (must not clear), a mode input flipped after reset release (must not change the scheme), simultaneous strobes, and back-to-back mismatches to show the failure flag is a single-cycle pulse per attempt.

// File: rtl/sprot_pkg.sv
package sprot_pkg;

    typedef enum logic {
        MODE_PERSIST  = 1'b0,
        MODE_PASSWORD = 1'b1
    } prot_mode_e;

    typedef struct packed {
        logic lock_set;
        logic pw_unlock;
        logic pw_match;
    } lock_cmd_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_SET    = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_REJECT = 2'd3
    } lock_act_e;

    // Lock value a reset leaves behind, chosen by the scheme in force.
    function automatic logic lock_after_reset(prot_mode_e m);
        return (m == MODE_PASSWORD);
    endfunction

    // Priority: lock-set, then unlock (only in password mode).
    function automatic lock_act_e resolve_cmd(lock_cmd_t c, prot_mode_e m);
        lock_act_e a;
        a = ACT_NONE;
        if (c.lock_set) begin
            a = ACT_SET;
        end else if (c.pw_unlock && (m == MODE_PASSWORD)) begin
            a = c.pw_match ? ACT_CLEAR : ACT_REJECT;
        end
        return a;
    endfunction

endpackage

// File: rtl/sprot_mode_latch.sv
module sprot_mode_latch
    import sprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_any,
    input  prot_mode_e mode_in,
    output prot_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            mode_q <= mode_in;
        end
    end

    // R9
    mode_held_chk: assert property (@(posedge clk) disable iff (rst_any)
        !$past(rst_any) |-> $stable(mode_q));

endmodule

// File: rtl/sprot_cmd_arb.sv
module sprot_cmd_arb
    import sprot_pkg::*;
(
    input  lock_cmd_t  cmd,
    input  prot_mode_e mode,
    output lock_act_e  act
);

    always_comb begin
        act = resolve_cmd(cmd, mode);
    end

endmodule

// File: rtl/sprot_lock_reg.sv
module sprot_lock_reg
    import sprot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_any,
    input  logic      rst_value,
    input  lock_act_e act,
    output logic      lock_q,
    output logic      fail_q
);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            lock_q <= rst_value;
            fail_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_SET: begin
                    lock_q <= 1'b1;
                    fail_q <= 1'b0;
                end
                ACT_CLEAR: begin
                    lock_q <= 1'b0;
                    fail_q <= 1'b0;
                end
                ACT_REJECT: begin
                    fail_q <= 1'b1;
                end
                default: begin
                    fail_q <= 1'b0;
                end
            endcase
        end
    end

    // R1 R2
    reset_value_chk: assert property (@(posedge clk)
        $past(rst_any) |-> (lock_q == $past(rst_value)));

    // R3
    set_takes_chk: assert property (@(posedge clk) disable iff (rst_any)
        (act == ACT_SET) |=> lock_q);

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst_any)
        (act == ACT_CLEAR) |=> !lock_q);

    // R4 R7
    fall_source_chk: assert property (@(posedge clk) disable iff (rst_any)
        ($fell(lock_q) && !$past(rst_any)) |-> ($past(act) == ACT_CLEAR));

    // R5
    fail_source_chk: assert property (@(posedge clk) disable iff (rst_any)
        (fail_q && !$past(rst_any)) |-> ($past(act) == ACT_REJECT));

    // R5
    reject_keeps_chk: assert property (@(posedge clk) disable iff (rst_any)
        (act == ACT_REJECT) |=> ($stable(lock_q) && fail_q));

endmodule

// File: rtl/sprot_lock_ctrl.sv
module sprot_lock_ctrl
    import sprot_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic hw_rst,
    input  logic mode_nv,
    input  logic cmd_lock_set,
    input  logic cmd_pw_unlock,
    input  logic pw_match,
    output logic lock_o,
    output logic prot_mod_en_o,
    output logic unlock_fail_o
);

    logic       rst_any;
    prot_mode_e mode_in;
    prot_mode_e mode_q;
    lock_cmd_t  cmd;
    lock_act_e  act;
    logic       rst_value;
    logic       lock_q;
    logic       fail_q;

    assign rst_any   = por | hw_rst;
    assign mode_in   = prot_mode_e'(mode_nv);
    assign rst_value = lock_after_reset(mode_in);

    always_comb begin
        cmd.lock_set  = cmd_lock_set;
        cmd.pw_unlock = cmd_pw_unlock;
        cmd.pw_match  = pw_match;
    end

    sprot_mode_latch u_mode (
        .clk     (clk),
        .rst_any (rst_any),
        .mode_in (mode_in),
        .mode_q  (mode_q)
    );

    sprot_cmd_arb u_arb (
        .cmd  (cmd),
        .mode (mode_q),
        .act  (act)
    );

    sprot_lock_reg u_lock (
        .clk       (clk),
        .rst_any   (rst_any),
        .rst_value (rst_value),
        .act       (act),
        .lock_q    (lock_q),
        .fail_q    (fail_q)
    );

    assign lock_o        = lock_q;
    assign unlock_fail_o = fail_q;
    assign prot_mod_en_o = ~lock_q & ~rst_any;

    // R6
    persist_ignore_chk: assert property (@(posedge clk) disable iff (rst_any)
        (mode_q == MODE_PERSIST && cmd_pw_unlock && !cmd_lock_set)
        |=> ($stable(lock_o) && !unlock_fail_o));

    // R7
    persist_sticky_chk: assert property (@(posedge clk) disable iff (rst_any)
        (mode_q == MODE_PERSIST && lock_o) |=> lock_o);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst_any)
        (cmd_lock_set && cmd_pw_unlock) |=> (lock_o && !unlock_fail_o));

    // R8
    mod_en_chk: assert property (@(posedge clk) disable iff (rst_any)
        prot_mod_en_o |-> !lock_o);

endmodule

// File: tb/sprot_lock_ctrl_tb.sv
module sprot_lock_ctrl_tb_top;

    logic clk = 1'b0;
    logic por = 1'b0, hw_rst = 1'b0, mode_nv = 1'b0;
    logic cmd_lock_set = 1'b0, cmd_pw_unlock = 1'b0, pw_match = 1'b0;
    logic lock_o, prot_mod_en_o, unlock_fail_o;

    int   n_checks = 0;
    int   n_errors = 0;
    logic e_lock, e_fail, e_mode;

    always #2 clk = ~clk;

    sprot_lock_ctrl dut_i (
        .clk           (clk),
        .por           (por),
        .hw_rst        (hw_rst),
        .mode_nv       (mode_nv),
        .cmd_lock_set  (cmd_lock_set),
        .cmd_pw_unlock (cmd_pw_unlock),
        .pw_match      (pw_match),
        .lock_o        (lock_o),
        .prot_mod_en_o (prot_mod_en_o),
        .unlock_fail_o (unlock_fail_o)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(logic p, logic h, logic m, logic ls, logic pu, logic pm);
        if (p | h) return m ? "R1" : "R2";
        if (ls) return pu ? "R10" : "R3";
        if (pu) begin
            if (!e_mode) return "R6";
            return pm ? "R4" : "R5";
        end
        return "R8";
    endfunction

    task automatic step(input logic p, input logic h, input logic m, input logic ls,
                        input logic pu, input logic pm, input string req);
        @(negedge clk);
        por = p; hw_rst = h; mode_nv = m;
        cmd_lock_set = ls; cmd_pw_unlock = pu; pw_match = pm;
        if (p | h) begin
            e_mode = m; e_lock = m; e_fail = 1'b0;
        end else if (ls) begin
            e_lock = 1'b1; e_fail = 1'b0;
        end else if (pu && e_mode) begin
            if (pm) e_lock = 1'b0;
            e_fail = !pm;
        end else begin
            e_fail = 1'b0;
        end
        @(posedge clk);
        #1;
        check(lock_o, e_lock, req, "lock_o");
        check(unlock_fail_o, e_fail, req, "unlock_fail_o");
        check(prot_mod_en_o, !e_lock && !(p | h), "R8", "prot_mod_en_o");
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : stim
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);

        // R1: power-on reset in password mode, then hardware reset
        step(1, 0, 1, 0, 0, 0, "R1");
        step(0, 0, 1, 0, 0, 0, "R1");
        step(0, 1, 1, 0, 0, 0, "R1");
        step(0, 0, 1, 0, 0, 0, "R1");
        // R5: two mismatches in a row then idle: pulse per attempt, lock kept
        step(0, 0, 1, 0, 1, 0, "R5");
        step(0, 0, 1, 0, 1, 0, "R5");
        step(0, 0, 1, 0, 0, 0, "R5");
        // R4: matching unlock clears
        step(0, 0, 1, 0, 1, 1, "R4");
        step(0, 0, 1, 0, 0, 0, "R8");
        // R3: lock-set re-arms in password mode
        step(0, 0, 1, 1, 0, 0, "R3");
        // R10: both strobes together
        step(0, 0, 1, 0, 1, 1, "R4");
        step(0, 0, 1, 1, 1, 1, "R10");
        step(0, 0, 1, 1, 1, 0, "R10");
        // R1: reset from clear state restores lock
        step(0, 0, 1, 0, 1, 1, "R4");
        step(0, 1, 1, 0, 0, 0, "R1");
        // R2: persistent-mode reset clears
        step(1, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        // R6: unlock ignored while clear and while set
        step(0, 0, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 1, 1, "R6");
        step(0, 0, 0, 1, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 1, "R6");
        step(0, 0, 0, 0, 1, 0, "R6");
        // R7: sticky until reset
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 0, 0, "R7");
        // R9: mode input flips after release, persistent rules still apply
        step(0, 0, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 1, 0, 0, "R9");
        step(0, 0, 1, 0, 1, 1, "R9");
        step(0, 0, 1, 0, 1, 0, "R9");
        // R9: reset in password mode, mode input drops, unlock still honoured
        step(0, 1, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 0, "R9");
        step(0, 0, 0, 0, 1, 1, "R9");

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic p, h, m, ls, pu, pm;
            p  = ($urandom % 60) == 0;
            h  = ($urandom % 40) == 0;
            m  = ($urandom % 8) == 0 ? ~mode_nv : mode_nv;
            ls = ($urandom % 6) == 0;
            pu = ($urandom % 3) == 0;
            pm = $urandom % 2;
            step(p, h, m, ls, pu, pm, tag_of(p, h, m, ls, pu, pm));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule